// File: doc/BRIEF.md
# Frequency Offset Alarm Monitor

The monitor compares two candidate clocks with one reference clock and raises a separate, registered alarm for each candidate whose frequency strays from the reference by more than a chosen ppm limit. Every clock arrives already converted into single-cycle tick pulses in the system clock domain. A gate window is a fixed number of reference ticks. During that window each candidate's ticks are counted. At the close of the window the count is compared with the window length, and the alarm is rewritten.

Two trip limits are available. Each limit is fixed at build time as a parameter in parts per billion and turned into whole counts for the chosen window. `band_sel` low picks the tight limit, for stratum-class checking. `band_sel` high picks the loose limit, for minimum-clock checking. Raising `mon_off` stops all comparison, throws away the partial counts and forces both alarms low.

A three-state controller drives the sequencing:
- OFF: monitoring is disabled.
- COUNT: the gate window is running.
- JUDGE: a one-cycle verdict state after each window closes.

The transitions are:
- OFF→COUNT when `mon_off` is released.
- COUNT→JUDGE on the reference tick that closes the window.
- JUDGE→COUNT on the following cycle.
- Any state→OFF while `mon_off` is high.

Top module: `freq_offset_monitor`

## Requirements
- R1: After a synchronous reset both alarms are low and all tick counts start from zero.
- R2: A gate window closes on the WINDOW_REFS-th reference tick since the last close, reset or disable. An alarm is rewritten only on the second clock edge after that closing tick, and keeps its value at all other times.
- R3: At judgement, an alarm is set exactly when the absolute difference between the candidate tick count for the window and WINDOW_REFS is strictly greater than the active limit. A difference equal to the limit gives no alarm.
- R4: `band_sel` = 0 selects the tight limit and `band_sel` = 1 selects the loose limit. Each limit is round(WINDOW_REFS × ppb / 10^9) counts, with halves rounded up.
- R5: The two candidates are judged independently. Bit 0 of `cand_tick` drives bit 0 of `alarm`, and bit 1 drives bit 1.
- R6: While `mon_off` is high, both alarms are low from the next clock edge onward, and ticks are ignored. After release, a fresh window starts from zero counts.
- R7: A candidate tick in the same cycle as the closing reference tick is counted in the window that is closing.
- R8: A candidate that is too slow alarms the same way as one that is too fast. An alarm clears at the next judgement once the offset is back within the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle pulse per reference clock edge |
| cand_tick | input | 2 | One-cycle pulses per candidate clock edge, one bit per candidate |
| band_sel | input | 1 | Limit select: 0 tight, 1 loose |
| mon_off | input | 1 | High disables comparison and clears both alarms |
| alarm | output | 2 | Registered offset alarm per candidate, active high |

## Verification
The assertions assume that each tick input is a clean single-cycle pulse per edge of its source clock, already in the system domain. They also assume that WINDOW_REFS is at least 2, so that two window closes can never fall on adjacent cycles. The bench keeps to these assumptions. It drives reference ticks on a fixed four-cycle grid, and it places candidate ticks only on the other slots of that grid, except in the one case that deliberately makes a candidate tick coincide with the closing reference tick. Inputs change only at falling edges, and the `band_sel` setting for a window is fixed before the window starts.

// File: rtl/fom_pkg.sv
package fom_pkg;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_COUNT = 2'd1,
        S_JUDGE = 2'd2
    } mon_state_t;

    // Whole-count trip limit for a window, rounding halves up.
    function automatic longint unsigned trip_counts(input longint unsigned win,
                                                    input longint unsigned ppb);
        return (win * ppb + 64'd500_000_000) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/fom_gate_timer.sv
module fom_gate_timer #(
    parameter int unsigned WINDOW_REFS = 1 << 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic ref_tick,
    output logic window_end
);
    localparam int unsigned REF_W = $clog2(WINDOW_REFS + 1);
    localparam logic [REF_W-1:0] LAST = REF_W'(WINDOW_REFS - 1);

    logic [REF_W-1:0] ref_cnt;

    assign window_end = ref_tick && !clear && (ref_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || window_end) begin
            ref_cnt <= '0;
        end else if (ref_tick) begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

    // R2: two window closes are always at least one cycle apart
    a_r2_window_gap: assert property (@(posedge clk) disable iff (rst)
        window_end |=> !window_end);

endmodule

// File: rtl/fom_edge_counter.sv
module fom_edge_counter #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] cnt;

    // Count including this cycle's tick, saturating at all-ones.
    always_comb begin
        if (tick && cnt != '1) begin
            total = cnt + 1'b1;
        end else begin
            total = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else begin
            cnt <= total;
        end
    end

    // R1: reset leaves the count at zero
    a_r1_count_cleared: assert property (@(posedge clk)
        rst |=> cnt == '0);

endmodule

// File: rtl/fom_judge.sv
module fom_judge #(
    parameter int unsigned WINDOW_REFS = 1 << 20,
    parameter int unsigned CNT_W       = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             off,
    input  logic             capture,
    input  logic             decide,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] limit,
    output logic             alarm
);
    localparam logic [CNT_W-1:0] WIN = CNT_W'(WINDOW_REFS);

    logic [CNT_W-1:0] snap;
    logic [CNT_W-1:0] diff;

    always_comb begin
        if (snap >= WIN) begin
            diff = snap - WIN;
        end else begin
            diff = WIN - snap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (capture) begin
            snap <= total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || off) begin
            alarm <= 1'b0;
        end else if (decide) begin
            alarm <= (diff > limit);
        end
    end

    // R2: without a verdict or a disable the alarm holds its value
    a_r2_alarm_hold: assert property (@(posedge clk) disable iff (rst)
        (!decide && !off) |=> $stable(alarm));

endmodule

// File: rtl/freq_offset_monitor.sv
module freq_offset_monitor #(
    parameter int unsigned WINDOW_REFS = 1 << 20,
    parameter int unsigned TIGHT_PPB   = 12_000,
    parameter int unsigned LOOSE_PPB   = 56_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic [1:0] cand_tick,
    input  logic       band_sel,
    input  logic       mon_off,
    output logic [1:0] alarm
);
    import fom_pkg::*;

    localparam int unsigned NCAND = 2;
    localparam int unsigned CNT_W = $clog2(WINDOW_REFS) + 3;
    localparam logic [CNT_W-1:0] LIM_TIGHT = CNT_W'(trip_counts(WINDOW_REFS, TIGHT_PPB));
    localparam logic [CNT_W-1:0] LIM_LOOSE = CNT_W'(trip_counts(WINDOW_REFS, LOOSE_PPB));

    mon_state_t       state;
    mon_state_t       state_nx;
    logic             window_end;
    logic             capture;
    logic             decide;
    logic [CNT_W-1:0] limit;

    fom_gate_timer #(
        .WINDOW_REFS(WINDOW_REFS)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .clear     (mon_off),
        .ref_tick  (ref_tick),
        .window_end(window_end)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_COUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:   state_nx = mon_off ? S_OFF : S_COUNT;
            S_COUNT: state_nx = mon_off ? S_OFF : (window_end ? S_JUDGE : S_COUNT);
            S_JUDGE: state_nx = mon_off ? S_OFF : S_COUNT;
            default: state_nx = S_OFF;
        endcase
    end

    // Output controls
    always_comb begin
        capture = window_end;
        decide  = (state == S_JUDGE) && !mon_off;
        limit   = band_sel ? LIM_LOOSE : LIM_TIGHT;
    end

    for (genvar g = 0; g < NCAND; g++) begin : g_cand
        logic [CNT_W-1:0] total;

        fom_edge_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clear(mon_off || window_end),
            .tick (cand_tick[g]),
            .total(total)
        );

        fom_judge #(
            .WINDOW_REFS(WINDOW_REFS),
            .CNT_W      (CNT_W)
        ) u_judge (
            .clk    (clk),
            .rst    (rst),
            .off    (mon_off),
            .capture(capture),
            .decide (decide),
            .total  (total),
            .limit  (limit),
            .alarm  (alarm[g])
        );
    end

    // R6: a disable clears both alarms at the next edge
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (rst)
        mon_off |=> alarm == 2'b00);

    // R1: reset leaves both alarms low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> alarm == 2'b00);

    // R2: a window only closes while counting
    a_r2_close_in_count: assert property (@(posedge clk) disable iff (rst)
        (window_end && !mon_off) |-> state == S_COUNT);

    // R2: a verdict state always returns to counting or disable
    a_r2_judge_once: assert property (@(posedge clk) disable iff (rst)
        state == S_JUDGE |=> state != S_JUDGE);

endmodule

// File: tb/freq_offset_monitor_test.sv
module freq_offset_monitor_test;

    localparam int unsigned WIN = 200;
    // tight limit round(200*0.01)=2, loose limit round(200*0.03)=6
    localparam int unsigned TPPB = 10_000_000;
    localparam int unsigned LPPB = 30_000_000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic [1:0] cand_tick = 2'b00;
    logic       band_sel = 1'b0;
    logic       mon_off = 1'b0;
    logic [1:0] alarm;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    freq_offset_monitor #(
        .WINDOW_REFS(WIN),
        .TIGHT_PPB  (TPPB),
        .LOOSE_PPB  (LPPB)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .cand_tick(cand_tick),
        .band_sel (band_sel),
        .mon_off  (mon_off),
        .alarm    (alarm)
    );

    typedef struct packed {
        logic       band;
        logic [9:0] na;
        logic [9:0] nb;
        logic       ea;
        logic       eb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'd200, 10'd200, 1'b0, 1'b0}, // R3 matched
        '{1'b0, 10'd202, 10'd198, 1'b0, 1'b0}, // R3 equal to limit
        '{1'b0, 10'd203, 10'd200, 1'b1, 1'b0}, // R3 R5 fast a
        '{1'b0, 10'd200, 10'd197, 1'b0, 1'b1}, // R8 slow b
        '{1'b1, 10'd203, 10'd197, 1'b0, 1'b0}, // R4 loose hides
        '{1'b1, 10'd206, 10'd194, 1'b0, 1'b0}, // R4 loose edge
        '{1'b1, 10'd207, 10'd193, 1'b1, 1'b1}, // R4 loose trip
        '{1'b0, 10'd200, 10'd200, 1'b0, 1'b0}, // R8 clears
        '{1'b1, 10'd210, 10'd200, 1'b1, 1'b0}  // R5 a only
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: alarm=%b expected %b", req, act, exp);
        end
    endtask

    // Ref tick every 4 cycles; candidate ticks on slots 1 and 2.
    task automatic run(input int nref, input int na, input int nb, input bit coinc);
        for (int i = 0; i < nref * 4; i++) begin
            @(negedge clk);
            ref_tick     = (i % 4 == 3);
            cand_tick[0] = ((i % 4 == 1) && (i / 4 < na)) ||
                           ((i % 4 == 2) && (i / 4 < na - nref)) ||
                           (coinc && i == nref * 4 - 1);
            cand_tick[1] = ((i % 4 == 1) && (i / 4 < nb)) ||
                           ((i % 4 == 2) && (i / 4 < nb - nref));
        end
        @(negedge clk);
        ref_tick  = 1'b0;
        cand_tick = 2'b00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        rst = 1'b0;
        idle(1);
        check("R1 reset", alarm, 2'b00);

        for (int v = 0; v < NV; v++) begin
            band_sel = VECS[v].band;
            run(WIN, int'(VECS[v].na), int'(VECS[v].nb), 1'b0);
            idle(3);
            check($sformatf("R3/R4/R5/R8 vector %0d", v), alarm, {VECS[v].eb, VECS[v].ea});
        end

        // R2: alarm (a=1) holds through half a window, then judged in full
        band_sel = 1'b0;
        run(WIN / 2, 0, 0, 1'b0);
        check("R2 hold mid-window", alarm, 2'b01);
        run(WIN / 2, 200, 200, 1'b0);
        idle(3);
        check("R2 window of two halves", alarm, 2'b00);

        // R7: coincident tick counts in closing window: 202+1 > 2
        run(WIN, 202, 200, 1'b1);
        idle(3);
        check("R7 coincident tick", alarm, 2'b01);

        // R6: disable clears alarm and ignores ticks
        @(negedge clk);
        mon_off = 1'b1;
        idle(1);
        check("R6 off clears", alarm, 2'b00);
        run(WIN, 250, 150, 1'b0);
        idle(3);
        check("R6 ticks ignored", alarm, 2'b00);
        mon_off = 1'b0;
        run(WIN, 203, 200, 1'b0);
        idle(3);
        check("R6 fresh window after release", alarm, 2'b01);

        // R1: reset mid-window clears alarm and counts
        run(WIN / 2, 150, 100, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        check("R1 reset clears alarm", alarm, 2'b00);
        run(WIN, 200, 200, 1'b0);
        idle(3);
        check("R1 counts restart", alarm, 2'b00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule